// File: doc/BRIEF.md
# Arc Trip and Graded Recovery Controller

This block supervises one high-voltage output channel against vacuum arcs. Two asynchronous comparator flags come in, one raised by an excessive current slope and one by a sudden collapse of the output voltage, together with a severity flag for the event. Either comparator flag trips the channel. A trip drives three independent shutdown outputs in the same clock cycle: one blocks the inverter drive, one opens the high-voltage solid-state switch and one enables the residual-charge bleed path.

After a trip the controller holds the channel off for a fixed time, then ramps a setpoint scale factor back up in programmable steps. How far it ramps depends on the event. An ordinary arc brings the channel back to the setpoint it had before. An arc that completes a burst of closely spaced arcs first lowers that setpoint by a fixed fraction, but never below a floor. A severe breakdown latches the channel off until the synchronous reset is applied. A saturating counter reports every accepted arc, so that an aging sequence run elsewhere can read it and adapt.

Top module: `arc_guard_ctrl`

## Requirements
- R1: After reset, `drv_block`, `sw_open`, `bleed_on` and `locked` are 0, `arc_count` is 0, and `scale` is full scale (2^SCALE_W-1, which is 1023 by default).
- R2: A high level on either `det_slope_a` or `det_drop_a` raises the three cut outputs after exactly three rising clock edges. The flag is set before edge 1, the outputs are high after edge 3 and are still low after edge 2. This holds whether the channel is running or ramping.
- R3: `drv_block`, `sw_open` and `bleed_on` always carry the same value. After a non-severe arc they stay high for 1+HOLD_CYC cycles and then fall together.
- R4: While the cut outputs are high, `scale` is 0. Comparator flags that arrive while the outputs are already cut are ignored: they add nothing to `arc_count` and do not change the release time.
- R5: After the hold, `scale` starts at 0 and rises by `ramp_step` once every RAMP_DIV cycles, clamped at the current target. The first step appears RAMP_DIV cycles after release. While the cut outputs stay low, `scale` never decreases.
- R6: A non-severe arc that is not frequent leaves the target unchanged, so `scale` settles back at its value from before the arc.
- R7: An arc is frequent when it and the arcs accepted in the preceding WIN_CYC cycles number at least FREQ_N. A frequent non-severe arc lowers the target to target - (target >> DERATE_SHIFT), or to FLOOR if that result is smaller.
- R8: An arc whose `arc_severe` is 1 (sampled with the comparator flags) sets `locked` one cycle after the cut outputs rise. `locked` and the cut outputs then stay high, and `scale` stays 0, until `rst`.
- R9: `arc_count` increases by exactly one for each accepted arc, in the same cycle the cut outputs rise.
- R10: An arc during the ramp is accepted and restarts the whole trip, hold and ramp sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the only exit from lockout |
| det_slope_a | input | 1 | Asynchronous current-slope comparator flag |
| det_drop_a | input | 1 | Asynchronous voltage-collapse comparator flag |
| arc_severe | input | 1 | Severity of the event, 1 means severe breakdown; synchronised with the flags |
| ramp_step | input | SCALE_W | Scale increment per ramp tick |
| drv_block | output | 1 | Blocks inverter drive |
| sw_open | output | 1 | Opens the high-voltage switch |
| bleed_on | output | 1 | Enables the residual-charge bleed |
| scale | output | SCALE_W | Setpoint scale factor |
| arc_count | output | CNT_W | Saturating count of accepted arcs |
| locked | output | 1 | Latched severe-fault flag |

## Verification
Take edge 0 as the last edge before a comparator flag is applied.
- The cut outputs, `scale` = 0 and the new `arc_count` are due after edge 3. `locked` is due after edge 4.
- The cut outputs are released after edge 4+HOLD_CYC, and ramp step m lands after edge 4+HOLD_CYC+m*RAMP_DIV.

The bench works out each of these edge numbers from the requirements when it applies the stimulus. It files every expected value in the scoreboard under that cycle number, and the monitor compares it on the falling edge of exactly that cycle. The bench also checks the value one cycle before each rise or release, so an early or late output is reported.

// File: rtl/arc_pkg.sv
package arc_pkg;
  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_TRIP = 3'd1,
    ST_HOLD = 3'd2,
    ST_RAMP = 3'd3,
    ST_LOCK = 3'd4
  } arc_state_t;
endpackage

// File: rtl/arc_sync.sv
// Two-stage synchroniser for a bundle of asynchronous level inputs.
module arc_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q, stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/arc_rate_mon.sv
// Sliding-window count of accepted arcs.
module arc_rate_mon #(
  parameter int WIN_CYC = 256,
  parameter int FREQ_N  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  output logic frequent
);
  localparam int CW = $clog2(WIN_CYC + 1);

  logic [WIN_CYC-1:0] hist_q;
  logic [CW-1:0]      cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else begin
      hist_q <= {hist_q[WIN_CYC-2:0], hit};
      cnt_q  <= cnt_q + CW'(hit) - CW'(hist_q[WIN_CYC-1]);
    end
  end

  // The arc being accepted now, plus the ones still inside the window.
  assign frequent = (32'(cnt_q) + 32'd1) >= 32'(FREQ_N);
endmodule

// File: rtl/arc_setpoint.sv
// Target setpoint with derating, and the ramped output scale.
module arc_setpoint #(
  parameter int SCALE_W      = 10,
  parameter int DERATE_SHIFT = 3,
  parameter int FLOOR        = 300
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               derate,
  input  logic               tick,
  input  logic [SCALE_W-1:0] step,
  output logic [SCALE_W-1:0] scale,
  output logic               at_target
);
  localparam logic [SCALE_W-1:0] FULL    = {SCALE_W{1'b1}};
  localparam logic [SCALE_W-1:0] FLOOR_V = SCALE_W'(FLOOR);

  logic [SCALE_W-1:0] target_q, scale_q;
  logic [SCALE_W-1:0] derated, target_nx, stepped;
  logic [SCALE_W:0]   sum;

  always_comb begin
    derated   = target_q - (target_q >> DERATE_SHIFT);
    target_nx = (derated < FLOOR_V) ? FLOOR_V : derated;
    sum       = {1'b0, scale_q} + {1'b0, step};
    stepped   = (sum > {1'b0, target_q}) ? target_q : sum[SCALE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      target_q <= FULL;
      scale_q  <= FULL;
    end else begin
      if (derate) target_q <= target_nx;
      if (clr)       scale_q <= '0;
      else if (tick) scale_q <= stepped;
    end
  end

  assign scale     = scale_q;
  assign at_target = (scale_q == target_q);
endmodule

// File: rtl/arc_guard_ctrl.sv
// Arc trip and graded recovery controller for one output channel.
module arc_guard_ctrl
  import arc_pkg::*;
#(
  parameter int SCALE_W      = 10,
  parameter int CNT_W        = 8,
  parameter int HOLD_CYC     = 8,
  parameter int RAMP_DIV     = 4,
  parameter int WIN_CYC      = 256,
  parameter int FREQ_N       = 3,
  parameter int DERATE_SHIFT = 3,
  parameter int FLOOR        = 300
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               det_slope_a,
  input  logic               det_drop_a,
  input  logic               arc_severe,
  input  logic [SCALE_W-1:0] ramp_step,
  output logic               drv_block,
  output logic               sw_open,
  output logic               bleed_on,
  output logic [SCALE_W-1:0] scale,
  output logic [CNT_W-1:0]   arc_count,
  output logic               locked
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int RW = $clog2(RAMP_DIV + 1);
  localparam logic [HW-1:0] HOLD_LD   = HW'(HOLD_CYC - 1);
  localparam logic [RW-1:0] RDIV_LAST = RW'(RAMP_DIV - 1);

  logic [2:0]       sy;
  logic             trip_req, accept, frequent, at_target;
  logic             severe_q, freq_q;
  arc_state_t       st_q, st_nx;
  logic [HW-1:0]    hold_q;
  logic [RW-1:0]    rdiv_q;
  logic             tick, derate, clr, cut_nx;
  logic             cut_a_q, cut_b_q, cut_c_q, lock_q;
  logic [CNT_W-1:0] cnt_q;

  arc_sync #(.WIDTH(3)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({arc_severe, det_drop_a, det_slope_a}),
    .q   (sy)
  );

  // Either comparator trips; arcs are accepted only while the output is live.
  assign trip_req = sy[0] | sy[1];
  assign accept   = trip_req && (st_q == ST_RUN || st_q == ST_RAMP);

  arc_rate_mon #(.WIN_CYC(WIN_CYC), .FREQ_N(FREQ_N)) u_rate (
    .clk      (clk),
    .rst      (rst),
    .hit      (accept),
    .frequent (frequent)
  );

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      ST_RUN:  if (accept) st_nx = ST_TRIP;
      ST_TRIP: st_nx = severe_q ? ST_LOCK : ST_HOLD;
      ST_HOLD: if (hold_q == '0) st_nx = ST_RAMP;
      ST_RAMP: begin
        if (accept)         st_nx = ST_TRIP;
        else if (at_target) st_nx = ST_RUN;
      end
      ST_LOCK: st_nx = ST_LOCK;
      default: st_nx = ST_LOCK;
    endcase
  end

  assign clr    = (st_nx == ST_TRIP);
  assign derate = (st_q == ST_TRIP) && !severe_q && freq_q;
  assign tick   = (st_q == ST_RAMP) && !accept && !at_target && (rdiv_q == RDIV_LAST);
  assign cut_nx = (st_nx == ST_TRIP) || (st_nx == ST_HOLD) || (st_nx == ST_LOCK);

  arc_setpoint #(
    .SCALE_W(SCALE_W), .DERATE_SHIFT(DERATE_SHIFT), .FLOOR(FLOOR)
  ) u_setpt (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .derate    (derate),
    .tick      (tick),
    .step      (ramp_step),
    .scale     (scale),
    .at_target (at_target)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_RUN;
      severe_q <= 1'b0;
      freq_q   <= 1'b0;
      hold_q   <= '0;
      rdiv_q   <= '0;
      cut_a_q  <= 1'b0;
      cut_b_q  <= 1'b0;
      cut_c_q  <= 1'b0;
      lock_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      st_q <= st_nx;
      if (accept) begin
        severe_q <= sy[2];
        freq_q   <= frequent;
        if (cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + CNT_W'(1);
      end
      if (st_q == ST_TRIP)                     hold_q <= HOLD_LD;
      else if (st_q == ST_HOLD && hold_q != '0) hold_q <= hold_q - HW'(1);
      if (st_q != ST_RAMP || rdiv_q == RDIV_LAST) rdiv_q <= '0;
      else                                        rdiv_q <= rdiv_q + RW'(1);
      // Three separate registers, one per shutdown action.
      cut_a_q <= cut_nx;
      cut_b_q <= cut_nx;
      cut_c_q <= cut_nx;
      lock_q  <= (st_nx == ST_LOCK);
    end
  end

  assign drv_block = cut_a_q;
  assign sw_open   = cut_b_q;
  assign bleed_on  = cut_c_q;
  assign arc_count = cnt_q;
  assign locked    = lock_q;
endmodule

// File: rtl/arc_guard_chk.sv
module arc_guard_chk #(
  parameter int SCALE_W = 10,
  parameter int CNT_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               drv_block,
  input logic               sw_open,
  input logic               bleed_on,
  input logic [SCALE_W-1:0] scale,
  input logic [CNT_W-1:0]   arc_count,
  input logic               locked
);
  assert_cut_agree_R3: assert property (@(posedge clk) disable iff (rst)
    (drv_block == sw_open) && (sw_open == bleed_on));

  assert_scale_zero_R4: assert property (@(posedge clk) disable iff (rst)
    drv_block |-> (scale == '0));

  assert_ramp_mono_R5: assert property (@(posedge clk) disable iff (rst)
    !drv_block |=> (drv_block || scale >= $past(scale)));

  assert_lock_hold_R8: assert property (@(posedge clk) disable iff (rst)
    locked |=> (locked && drv_block));

  assert_lock_after_cut_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(drv_block));

  assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_block) |-> (arc_count == $past(arc_count) + CNT_W'(1)
                          || $past(arc_count) == {CNT_W{1'b1}}));

  assert_count_only_on_trip_R9: assert property (@(posedge clk) disable iff (rst)
    (arc_count != $past(arc_count)) |-> $rose(drv_block));
endmodule

bind arc_guard_ctrl arc_guard_chk #(.SCALE_W(SCALE_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .drv_block (drv_block),
  .sw_open   (sw_open),
  .bleed_on  (bleed_on),
  .scale     (scale),
  .arc_count (arc_count),
  .locked    (locked)
);

// File: tb/test_arc_guard_ctrl.sv
`timescale 1ns/1ps
module test_arc_guard_ctrl;
  localparam int H     = 8;
  localparam int D     = 4;
  localparam int WIN   = 256;
  localparam int NFREQ = 3;
  localparam int SH    = 3;
  localparam int FLOOR = 300;
  localparam int FULL  = 1023;

  localparam int K_CUT = 0, K_SCALE = 1, K_CNT = 2, K_LOCK = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       det_slope_a = 1'b0, det_drop_a = 1'b0, arc_severe = 1'b0;
  logic [9:0] ramp_step = 10'd1;
  logic       drv_block, sw_open, bleed_on, locked;
  logic [9:0] scale;
  logic [7:0] arc_count;

  arc_guard_ctrl i_arc_guard_ctrl (
    .clk(clk), .rst(rst), .det_slope_a(det_slope_a), .det_drop_a(det_drop_a),
    .arc_severe(arc_severe), .ramp_step(ramp_step), .drv_block(drv_block),
    .sw_open(sw_open), .bleed_on(bleed_on), .scale(scale),
    .arc_count(arc_count), .locked(locked)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    int    kind;
    int    val;
    string req;
  } exp_t;
  exp_t sb[$];

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // Reference model state
  int tgt_m = FULL;
  int cnt_m = 0;
  int acc_hist[$];

  task automatic expect_at(input int at, input int kind, input int val, input string req);
    exp_t e;
    e.at = at; e.kind = kind; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  // Monitor: compares every item that is due in the current cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        int act, ev;
        ev = sb[i].val;
        case (sb[i].kind)
          K_CUT:   begin act = int'({drv_block, sw_open, bleed_on}); ev = sb[i].val ? 7 : 0; end
          K_SCALE: act = int'(scale);
          K_CNT:   act = int'(arc_count);
          default: act = int'(locked);
        endcase
        n_cmp++;
        if (act != ev) begin
          n_bad++;
          $display("FAIL %s: kind %0d at cycle %0d actual %0d expected %0d",
                   sb[i].req, sb[i].kind, cyc, act, ev);
        end
        sb.delete(i);
      end
    end
  end

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Applies one comparator pulse and files the expected results under their cycles.
  // full = 0 files only the checks up to the first ramp step (for a following re-trip).
  task automatic arc(input bit slope, input bit drop, input bit sev, input int step,
                     input bit pulse_in_hold, input bit full, input string rise_req);
    int k, a, m_last, fin;
    bit freq;
    string done_req;
    @(negedge clk);
    k = cyc;
    det_slope_a = slope;
    det_drop_a  = drop;
    arc_severe  = sev;
    ramp_step   = 10'(step);
    a = k + 3;
    while (acc_hist.size() > 0 && a - acc_hist[0] > WIN) void'(acc_hist.pop_front());
    acc_hist.push_back(a);
    freq = (acc_hist.size() >= NFREQ);
    cnt_m++;
    expect_at(k + 2, K_CUT, 0, "R2");
    expect_at(k + 3, K_CUT, 1, rise_req);
    expect_at(k + 3, K_CNT, cnt_m, "R9");
    expect_at(k + 3, K_SCALE, 0, "R4");
    if (sev) begin
      expect_at(k + 3, K_LOCK, 0, "R8");
      expect_at(k + 4, K_LOCK, 1, "R8");
      expect_at(k + 20, K_CUT, 1, "R8");
      expect_at(k + 20, K_SCALE, 0, "R8");
      fin = k + 21;
    end else begin
      if (freq) begin
        tgt_m = tgt_m - (tgt_m >> SH);
        if (tgt_m < FLOOR) tgt_m = FLOOR;
      end
      done_req = freq ? "R7" : "R6";
      expect_at(k + 3 + H, K_CUT, 1, "R3");
      expect_at(k + 4 + H, K_CUT, 0, "R3");
      expect_at(k + 4 + H, K_SCALE, 0, "R5");
      expect_at(k + 3 + H + D, K_SCALE, 0, "R5");
      m_last = (tgt_m + step - 1) / step;
      if (!full) m_last = 1;
      for (int m = 1; m <= m_last; m++) begin
        int v;
        v = m * step;
        if (v > tgt_m) v = tgt_m;
        expect_at(k + 4 + H + m * D, K_SCALE, v, (m * step >= tgt_m) ? done_req : "R5");
      end
      fin = k + 4 + H + m_last * D + 1;
      if (full) begin
        expect_at(fin + 4, K_SCALE, tgt_m, done_req);
        expect_at(fin + 4, K_CUT, 0, "R5");
        expect_at(fin + 4, K_CNT, cnt_m, "R4");
        fin = fin + 5;
      end
    end
    @(negedge clk);
    det_slope_a = 1'b0;
    det_drop_a  = 1'b0;
    if (pulse_in_hold) begin
      wait_until(k + 5);
      det_drop_a = 1'b1;
      @(negedge clk);
      det_drop_a = 1'b0;
    end
    wait_until(fin);
    arc_severe = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1;
    det_slope_a = 1'b0; det_drop_a = 1'b0; arc_severe = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tgt_m = FULL; cnt_m = 0;
    acc_hist.delete();
    expect_at(cyc + 1, K_CUT, 0, "R1");
    expect_at(cyc + 1, K_SCALE, FULL, "R1");
    expect_at(cyc + 1, K_CNT, 0, "R1");
    expect_at(cyc + 1, K_LOCK, 0, "R1");
    wait_until(cyc + 3);
  endtask

  task automatic summary;
    foreach (sb[i]) begin
      n_cmp++; n_bad++;
      $display("FAIL %s: item due at cycle %0d never compared, actual none expected %0d",
               sb[i].req, sb[i].at, sb[i].val);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    int k0;
    do_reset();
    // R2/R6: slope flag alone, minor arc, not frequent
    arc(1, 0, 0, 512, 0, 1, "R2");
    // R4: drop flag alone with an extra flag during the hold (ignored)
    arc(0, 1, 0, 300, 1, 1, "R2");
    // R7: third arc inside the window lowers the target
    arc(1, 1, 0, 1023, 0, 1, "R2");
    // R6: after the window empties, the lowered target is restored unchanged
    repeat (WIN + 20) @(negedge clk);
    arc(0, 1, 0, 200, 0, 1, "R2");
    // R10: arc during the ramp restarts the sequence
    k0 = cyc;
    arc(1, 0, 0, 100, 0, 0, "R2");
    wait_until(k0 + 7 + H + D);
    arc(0, 1, 0, 400, 0, 1, "R10");
    // R7: repeated frequent arcs drive the target down to the floor
    for (int i = 0; i < 11; i++) arc(1, 0, 0, 1023, 0, 1, "R2");
    // R8: severe breakdown latches
    arc(0, 1, 1, 256, 0, 1, "R2");
    @(negedge clk);
    det_slope_a = 1'b1;
    @(negedge clk);
    det_slope_a = 1'b0;
    expect_at(cyc + 8, K_CNT, cnt_m, "R8");
    expect_at(cyc + 8, K_LOCK, 1, "R8");
    expect_at(cyc + 8, K_CUT, 1, "R8");
    wait_until(cyc + 10);
    // R1: reset is the only way out of lockout
    do_reset();
    arc(1, 0, 0, 1023, 0, 1, "R2");
    repeat (4) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      summary();
      $finish;
    end
  end
endmodule